// File: doc/BRIEF.md
# Programmable-Rate Time-of-Day Counter

This block keeps a 64-bit time value for hardware timestamping. The time does not advance by one on every clock. A rate register sets two things: an 8-bit period in clock ticks, and a 24-bit step that is added once each time that period elapses. Software can pre-scale the step by a left shift. The low-order bits of the time then hold fractional nanoseconds and the upper bits hold whole nanoseconds, so small trims of the step give fine frequency adjustment. For example, a period of 1 with a step of 40<<18 suits a 25 MHz reference, and a period of 3 with a step of 125<<14 suits a 24 MHz reference.

Software uses a small register bus with write enable, read enable, a 2-bit address and 32-bit data. The time is loaded as two 32-bit halves: the low half first, then the high half. The time is read the same way. Reading the low half captures the high half in the same cycle, so the two halves of one read always belong to the same 64-bit value. The time wraps modulo 2^64. With heavy scaling this can happen within hours, so software is expected to sample it well before the wrap.

Top module: `systime_counter`

## Requirements
- R1: After reset the time, the rate register and the read data are all zero, and the time holds because the period is zero.
- R2: The rate register sits at address 2. Bits 31:24 hold the period and bits 23:0 hold the step. Reading address 2 returns the last value written.
- R3: With a nonzero period P, the time increases by the zero-extended step exactly once every P clocks. The first increase lands P clocks after the cycle that restarted the tick count.
- R4: A period of zero stops counting: the time keeps its value.
- R5: The time wraps modulo 2^64 when a step carries past the top bit.
- R6: Reading address 0 returns time bits 31:0 and, in the same cycle, copies time bits 63:32 into a shadow. Reading address 1 returns the shadow, however far the time has moved since.
- R7: Writing address 0 only stages a low word and leaves the running time unchanged. Writing address 1 loads the time with the written word in bits 63:32 and the staged word in bits 31:0, and restarts the tick count.
- R8: Writing the rate register restarts the tick count. No step is added in the cycle of that write.
- R9: Read data is registered. It appears on the clock after read enable and holds while read enable is low. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 time low, 1 time high, 2 rate, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |

## Verification
A tick counter that is off by one shows up at the ports as time values that lag or lead the expected step schedule. The error is visible within one period of any restart, and it grows with every period after that. A shadow that is not captured, or that is overwritten late, makes a high-half read disagree with the low half read just before it. This is most visible when the time crosses a 2^32 boundary between the two reads. A missing restart on a rate or load write shifts every later step by up to P-1 clocks, so each read after such a write exposes it.

// File: rtl/systime_pkg.sv
package systime_pkg;
  localparam int unsigned SYS_TIME_W = 64;
  localparam int unsigned SYS_BUS_W  = 32;
  localparam int unsigned SYS_PER_W  = 8;
  localparam int unsigned SYS_INC_W  = 24;

  typedef enum logic [1:0] {
    REG_TIME_LO = 2'd0,
    REG_TIME_HI = 2'd1,
    REG_RATE    = 2'd2,
    REG_SPARE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/systime_rstsync.sv
module systime_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/systime_tick.sv
module systime_tick #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic             restart,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    tick  = 1'b0;
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (period == '0) begin
      cnt_d = '0;
    end else if (cnt_q == period - PER_W'(1)) begin
      tick  = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PER_W'(1);
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (cnt_q < period)); // R3
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R8
  AST_NO_TICK_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !tick); // R8
endmodule

// File: rtl/systime_accum.sv
module systime_accum #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned INC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [INC_W-1:0]  inc_val,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_q
);
  logic [TIME_W-1:0] time_d;
  logic              time_en;

  always_comb begin
    time_d = time_q;
    if (load)      time_d = load_val;
    else if (tick) time_d = time_q + TIME_W'(inc_val);
  end

  assign time_en = load | tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (time_en) time_q <= time_d;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (time_q == $past(load_val))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(time_q)); // R4
endmodule

// File: rtl/systime_regif.sv
module systime_regif
  import systime_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned INC_W  = 24,
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [TIME_W-1:0] time_val,
  output logic [BUS_W-1:0]  rdata,
  output logic [PER_W-1:0]  rate_period,
  output logic [INC_W-1:0]  rate_inc,
  output logic              load,
  output logic [TIME_W-1:0] load_val,
  output logic              restart
);
  localparam int unsigned HI_W = TIME_W - BUS_W;

  logic [BUS_W-1:0] stage_q, stage_d;
  logic [BUS_W-1:0] rate_q,  rate_d;
  logic [HI_W-1:0]  shadow_q, shadow_d;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic             wr_lo, wr_hi, wr_rate, rd_lo;

  always_comb begin
    wr_lo   = wr_en && (addr == REG_TIME_LO);
    wr_hi   = wr_en && (addr == REG_TIME_HI);
    wr_rate = wr_en && (addr == REG_RATE);
    rd_lo   = rd_en && (addr == REG_TIME_LO);
  end

  always_comb begin
    stage_d  = wr_lo   ? wdata : stage_q;
    rate_d   = wr_rate ? wdata : rate_q;
    shadow_d = rd_lo   ? time_val[TIME_W-1:BUS_W] : shadow_q;
    rdata_d  = rdata_q;
    if (rd_en) begin
      unique case (addr)
        REG_TIME_LO: rdata_d = time_val[BUS_W-1:0];
        REG_TIME_HI: rdata_d = BUS_W'(shadow_q);
        REG_RATE:    rdata_d = rate_q;
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      rate_q   <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_lo)   stage_q  <= stage_d;
      if (wr_rate) rate_q   <= rate_d;
      if (rd_lo)   shadow_q <= shadow_d;
      if (rd_en)   rdata_q  <= rdata_d;
    end
  end

  assign rate_period = rate_q[BUS_W-1 -: PER_W];
  assign rate_inc    = rate_q[INC_W-1:0];
  assign load        = wr_hi;
  assign load_val    = {wdata[HI_W-1:0], stage_q};
  assign restart     = wr_hi | wr_rate;
  assign rdata       = rdata_q;

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (shadow_q == $past(time_val[TIME_W-1:BUS_W]))); // R6
  AST_SHADOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(shadow_q)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R9
endmodule

// File: rtl/systime_counter.sv
module systime_counter
  import systime_pkg::*;
#(
  parameter int unsigned TIME_W = SYS_TIME_W,
  parameter int unsigned BUS_W  = SYS_BUS_W,
  parameter int unsigned PER_W  = SYS_PER_W,
  parameter int unsigned INC_W  = SYS_INC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);
  logic              srst_n;
  logic [PER_W-1:0]  rate_period;
  logic [INC_W-1:0]  rate_inc;
  logic              load, restart, tick;
  logic [TIME_W-1:0] load_val, time_q;

  systime_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  systime_regif #(.BUS_W(BUS_W), .PER_W(PER_W), .INC_W(INC_W), .TIME_W(TIME_W)) u_regif (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .time_val(time_q), .rdata(rdata),
    .rate_period(rate_period), .rate_inc(rate_inc),
    .load(load), .load_val(load_val), .restart(restart)
  );

  systime_tick #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst_n(srst_n), .period(rate_period), .restart(restart), .tick(tick)
  );

  systime_accum #(.TIME_W(TIME_W), .INC_W(INC_W)) u_accum (
    .clk(clk), .rst_n(srst_n), .tick(tick), .inc_val(rate_inc),
    .load(load), .load_val(load_val), .time_q(time_q)
  );

  AST_ZERO_PERIOD_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    (rate_period == '0 && !load) |=> $stable(time_q)); // R4
  AST_STEP_ADDS: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && !load) |=> (time_q == $past(time_q) + TIME_W'($past(rate_inc)))); // R3
endmodule

// File: tb/systime_counter_tb_top.sv
`timescale 1ns/1ps
module systime_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  longint unsigned cyc = 0;

  logic [63:0]     m_base = '0;
  longint unsigned m_start = 0;
  logic [7:0]      m_per = '0;
  logic [23:0]     m_inc = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  systime_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [63:0] model(longint unsigned c);
    logic [63:0] k;
    if (m_per == 8'd0) return m_base;
    k = 64'(c - m_start) / 64'(m_per);
    return m_base + k * {40'd0, m_inc};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_rate(logic [7:0] p, logic [23:0] inc);
    logic [63:0] cur;
    cur = model(cyc);
    wr(2'd2, {p, inc});
    m_base = cur; m_start = cyc; m_per = p; m_inc = inc;
  endtask

  task automatic load_time(logic [63:0] v);
    wr(2'd0, v[31:0]);
    wr(2'd1, v[63:32]);
    m_base = v; m_start = cyc;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic read_pair(int gap, string req);
    logic [63:0] exp;
    logic [31:0] lo, hi;
    exp = model(cyc);
    rd(2'd0, lo);
    chk(lo == exp[31:0], {req, " low half"}, {32'd0, lo}, {32'd0, exp[31:0]});
    idle(gap);
    rd(2'd1, hi);
    chk(hi == exp[63:32], {req, " R6 high half from shadow"}, {32'd0, hi}, {32'd0, exp[63:32]});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep;
    void'($urandom(32'd2718));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    chk(rdata == 32'd0, "R1 rdata in reset", {32'd0, rdata}, 64'd0);
    rst_n = 1'b1;
    idle(4);
    // R1: everything zero, time holds with zero period
    rd(2'd2, v);
    chk(v == 32'd0, "R1 rate after reset", {32'd0, v}, 64'd0);
    idle(5);
    read_pair(0, "R1 time after reset");

    // R9: spare address reads zero; rdata holds while idle
    rd(2'd3, v);
    chk(v == 32'd0, "R9 spare address", {32'd0, v}, 64'd0);
    set_rate(8'd1, 24'd40 << 18);
    rd(2'd0, keep);
    idle(6);
    chk(rdata == keep, "R9 rdata holds", {32'd0, rdata}, {32'd0, keep});

    // R2: field layout readback
    rd(2'd2, v);
    chk(v == {8'd1, 24'd40 << 18}, "R2 rate readback", {32'd0, v}, {32'd0, 8'd1, 24'd40 << 18});

    // R3: period 1 and period 3 examples
    idle(10);
    read_pair(0, "R3 period 1");
    set_rate(8'd3, 24'd125 << 14);
    for (int i = 0; i < 5; i++) read_pair(i % 2, "R3 period 3");
    rd(2'd2, v);
    chk(v[31:24] == 8'd3 && v[23:0] == 24'd2048000, "R2 fields", {32'd0, v}, {32'd0, 8'd3, 24'd2048000});

    // R4: zero period holds
    set_rate(8'd0, 24'hFFFFFF);
    idle(9);
    read_pair(2, "R4 zero period");

    // R7: low write alone has no effect
    set_rate(8'd2, 24'd7);
    wr(2'd0, 32'hDEADBEEF);
    idle(3);
    read_pair(0, "R7 low write ignored");
    load_time(64'h0123_4567_89AB_CDEF);
    read_pair(0, "R7 load");

    // R8: rate rewrite restarts the count
    set_rate(8'd4, 24'd100);
    idle(2);
    set_rate(8'd4, 24'd100);
    read_pair(0, "R8 restart a");
    idle(1);
    read_pair(0, "R8 restart b");

    // R6: high half crosses after low read
    set_rate(8'd1, 24'h10);
    load_time(64'h0000_0007_FFFF_FFF0);
    read_pair(3, "R6 boundary");

    // R5: wrap
    load_time(64'hFFFF_FFFF_FFFF_FFF0);
    set_rate(8'd1, 24'h20);
    idle(2);
    read_pair(0, "R5 wrap");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: begin
          logic [7:0] p;
          p = ($urandom % 8 == 0) ? 8'd255 : 8'($urandom % 5);
          set_rate(p, 24'($urandom));
        end
        1: load_time({$urandom, $urandom});
        2: idle(1 + int'($urandom % 20));
        default: read_pair(int'($urandom % 4), "R3 random");
      endcase
    end
    read_pair(1, "R3 final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule